// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital timing controller that sits next to a successive-approximation converter. It divides the system clock down to a converter clock, counts converter cycles through each conversion, and emits the strobes the analog side needs. A select-update strobe marks the start of a conversion. A sample strobe closes the track-and-hold. A write strobe loads the finished result word. The comparator and DAC are not modelled; the converted value arrives as a supplied word `conv_word` and is captured at completion.

Software requests a conversion with a one-cycle `start_set` pulse. That pulse sets a start bit, readable on `start_rd`. Three modes are selected with `mode`. In single mode one conversion runs per request. In free-running mode conversions chain back to back. In trigger mode a synchronised rising edge on `trig` starts the conversion and realigns the prescaler, so the delay from trigger to sample is always the same. The first conversion after `en` rises is longer and samples later, to give the analog front end time to settle. Dropping `en` abandons any conversion in progress.

Every strobe and status output is a register. A strobe is high for one system-clock cycle, in the cycle after the edge that decides it.

Top module: `adc_seq`

## Requirements
- R1: After reset `start_rd`, `flag` and all strobes are low. A `start_set` pulse with `en` high sets `start_rd`. The conversion begins on the next converter-clock rising edge, marked by `mux_upd`, between 2 and CLK_DIV+1 cycles after the pulse cycle.
- R2: A conversion that is not the first after enable ends with `result_wr` exactly NORM_LEN*CLK_DIV (52) cycles after its `mux_upd`.
- R3: The first conversion after `en` rises ends FIRST_LEN*CLK_DIV (100) cycles after its `mux_upd`.
- R4: `sample_stb` pulses (NORM_SH+0.5)*CLK_DIV (14) cycles after `mux_upd` in a normal conversion, and (FIRST_SH+0.5)*CLK_DIV (54) cycles after it in a first conversion. The half-cycle point is the falling edge of the converter clock.
- R5: On `result_wr`, `result` holds the `conv_word` value present at the completion edge, and `flag` is set.
- R6: Single mode is `mode`=2'b00 (2'b11 behaves the same). In this mode `start_rd` drops on the same edge as `result_wr`, and no further conversion starts without a new request.
- R7: Free-running mode is `mode`=2'b01. At each completion, `mux_upd` of the next conversion pulses in the same cycle as `result_wr`. `start_rd` stays high, and completions are NORM_LEN*CLK_DIV cycles apart.
- R8: Trigger mode is `mode`=2'b10. A rising edge of `trig` first sampled at edge X starts the conversion at edge X+2, whatever the prescaler phase. In a non-first conversion `sample_stb` follows `mux_upd` by TRIG_SH*CLK_DIV (8) cycles. A first conversion keeps the R4 first-conversion sample point.
- R9: Rising edges of `trig` are ignored outside trigger mode and while a conversion is running.
- R10: Writing `flag_clr`=1 clears `flag`. Starting a new conversion does not clear it, and a completion on the same edge as a clear leaves it set.
- R11: With `en` low, any conversion is abandoned without `result_wr` and `start_rd` reads 0. The next conversion after re-enabling uses the first-conversion timing.
- R12: `start_set` pulses while `en` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable; low aborts and re-arms the long first conversion |
| start_set | input | 1 | One-cycle request that sets the start bit |
| mode | input | 2 | 00 single, 01 free-running, 10 trigger, 11 as single |
| trig | input | 1 | Asynchronous trigger source, rising edge active |
| flag_clr | input | 1 | Write-one-to-clear pulse for the completion flag |
| conv_word | input | RES_W | Converted value supplied by the analog side |
| sample_stb | output | 1 | Track-and-hold strobe |
| mux_upd | output | 1 | Input-select/reference update strobe at conversion start |
| result_wr | output | 1 | Result register write strobe at completion |
| result | output | RES_W | Last captured conversion result |
| flag | output | 1 | Completion flag |
| start_rd | output | 1 | Start bit readback |

## Verification
The bench measures each strobe's distance in system cycles from the conversion's `mux_upd`. A design that forgot the long first conversion, or sampled on the rising rather than the falling converter edge, would be off by whole or half converter cycles. Triggers are applied at every prescaler phase. A prescaler that was not realigned would show a start-to-trigger delay that drifts with phase. The bench also aims a flag clear exactly at a completion edge, re-fires the trigger mid-conversion, and drops the enable mid-conversion. A design that got these wrong would lose the flag, start a spurious second conversion, or resume with the short conversion length.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_FREE   = 2'b01,
        MODE_TRIG   = 2'b10,
        MODE_RSVD   = 2'b11
    } adc_mode_e;

endpackage

// File: rtl/adc_seq_presc.sv
module adc_seq_presc #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic realign,
    output logic rise,
    output logic fall
);
    localparam int PW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_DIV - 1);
    localparam logic [PW-1:0] HALF = PW'(CLK_DIV / 2);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)              cnt_d = '0;
        else if (realign)      cnt_d = PW'(1);
        else if (cnt_q == LAST) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign rise = run && (cnt_q == '0);
    assign fall = run && (cnt_q == HALF);

    // R8: a realigned prescaler treats the trigger cycle as the rising edge
    assert_realign_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (realign && run) |=> !rise);
    // R1: converter-clock rising edges are never back to back
    assert_rise_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/adc_seq_tsync.sv
module adc_seq_tsync (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic evt
);
    logic [2:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[1:0], trig_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign evt = sh_q[1] && !sh_q[2];

    // R8: one event per synchronised rising edge
    assert_evt_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int CLK_DIV   = 4,
    parameter int NORM_LEN  = 13,
    parameter int FIRST_LEN = 25,
    parameter int NORM_SH   = 3,
    parameter int FIRST_SH  = 13,
    parameter int TRIG_SH   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start_set,
    input  logic [1:0]       mode,
    input  logic             trig,
    input  logic             flag_clr,
    input  logic [RES_W-1:0] conv_word,
    output logic             sample_stb,
    output logic             mux_upd,
    output logic             result_wr,
    output logic [RES_W-1:0] result,
    output logic             flag,
    output logic             start_rd
);
    localparam int CW = $clog2(FIRST_LEN + 1);
    localparam logic [CW-1:0] LEN_N = CW'(NORM_LEN);
    localparam logic [CW-1:0] LEN_F = CW'(FIRST_LEN);
    localparam logic [CW-1:0] SMP_N = CW'(NORM_SH + 1);
    localparam logic [CW-1:0] SMP_F = CW'(FIRST_SH + 1);
    localparam logic [CW-1:0] SMP_T = CW'(TRIG_SH);

    typedef struct packed {
        logic             conv;
        logic             first;
        logic             start;
        logic             trg;
        logic             flag;
        logic             smp;
        logic             mux;
        logic             done;
        logic [CW-1:0]    acyc;
        logic [RES_W-1:0] res;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    adc_mode_e mode_e;
    logic      rise, fall, realign, trig_evt;
    logic [CW-1:0] len_sel, smp_sel;

    assign mode_e = adc_mode_e'(mode);

    adc_seq_presc #(.CLK_DIV(CLK_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(en), .realign(realign),
        .rise(rise), .fall(fall)
    );

    adc_seq_tsync u_tsync (
        .clk(clk), .rst_n(rst_n), .trig_in(trig), .evt(trig_evt)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.smp = 1'b0;
        ctl_d.mux = 1'b0;
        ctl_d.done = 1'b0;
        realign   = 1'b0;
        len_sel   = ctl_q.first ? LEN_F : LEN_N;
        smp_sel   = ctl_q.first ? SMP_F : SMP_N;

        if (flag_clr) ctl_d.flag = 1'b0;

        if (!en) begin
            ctl_d.conv  = 1'b0;
            ctl_d.first = 1'b1;
            ctl_d.start = 1'b0;
            ctl_d.trg   = 1'b0;
            ctl_d.acyc  = '0;
        end else if (!ctl_q.conv) begin
            if (mode_e == MODE_TRIG && trig_evt) begin
                realign     = 1'b1;
                ctl_d.conv  = 1'b1;
                ctl_d.trg   = 1'b1;
                ctl_d.start = 1'b1;
                ctl_d.acyc  = CW'(1);
                ctl_d.mux   = 1'b1;
            end else if (ctl_q.start && rise) begin
                ctl_d.conv  = 1'b1;
                ctl_d.trg   = 1'b0;
                ctl_d.acyc  = CW'(1);
                ctl_d.mux   = 1'b1;
            end
        end else begin
            if (ctl_q.trg && !ctl_q.first) begin
                if (rise && ctl_q.acyc == SMP_T) ctl_d.smp = 1'b1;
            end else if (fall && ctl_q.acyc == smp_sel) begin
                ctl_d.smp = 1'b1;
            end
            if (rise) begin
                if (ctl_q.acyc == len_sel) begin
                    ctl_d.done  = 1'b1;
                    ctl_d.flag  = 1'b1;
                    ctl_d.first = 1'b0;
                    ctl_d.res   = conv_word;
                    ctl_d.trg   = 1'b0;
                    if (mode_e == MODE_FREE) begin
                        ctl_d.acyc = CW'(1);
                        ctl_d.mux  = 1'b1;
                    end else begin
                        ctl_d.conv  = 1'b0;
                        ctl_d.start = 1'b0;
                        ctl_d.acyc  = '0;
                    end
                end else begin
                    ctl_d.acyc = ctl_q.acyc + 1'b1;
                end
            end
        end

        if (en && start_set) ctl_d.start = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.first <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sample_stb = ctl_q.smp;
    assign mux_upd    = ctl_q.mux;
    assign result_wr  = ctl_q.done;
    assign result     = ctl_q.res;
    assign flag       = ctl_q.flag;
    assign start_rd   = ctl_q.start;

    // R5: the flag only rises together with a result write
    assert_flag_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> result_wr);
    // R7: free-running completion chains straight into the next conversion
    assert_free_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (result_wr && $past(mode) == MODE_FREE) |-> (start_rd && mux_upd));
    // R6: single-mode completion drops the start bit
    assert_single_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (result_wr && $past(mode) == MODE_SINGLE && !$past(start_set)) |-> !start_rd);
    // R11: a disabled converter shows no activity
    assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!start_rd && !mux_upd && !result_wr && !sample_stb));
    // R10: a clear not coinciding with completion empties the flag
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_clr) && !result_wr) |-> !flag);
    // R4: the sample strobe only fires inside a conversion
    assert_sample_in_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> ctl_q.conv);
    // R3: the cycle count never passes the longest conversion
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.acyc <= LEN_F);

endmodule

// File: tb/adc_seq_test.sv
module adc_seq_test;
    localparam int CLK_NS = 10;
    localparam int RW  = 10;
    localparam int DIV = 4;
    localparam int NL  = 13;
    localparam int FL  = 25;
    localparam int NS  = 3;
    localparam int FS  = 13;
    localparam int TS  = 2;

    logic clk = 1'b0;
    logic rst_n, en, start_set, trig, flag_clr;
    logic [1:0] mode;
    logic [RW-1:0] word;
    logic sample_stb, mux_upd, result_wr, flag, start_rd;
    logic [RW-1:0] result;

    adc_seq uut (
        .clk(clk), .rst_n(rst_n), .en(en), .start_set(start_set), .mode(mode),
        .trig(trig), .flag_clr(flag_clr), .conv_word(word),
        .sample_stb(sample_stb), .mux_upd(mux_upd), .result_wr(result_wr),
        .result(result), .flag(flag), .start_rd(start_rd)
    );

    always #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int t_mux = -1, t_smp = -1, t_done = -1;
    int n_mux = 0, n_smp = 0, n_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mux_upd)    begin t_mux  = cyc; n_mux++;  end
            if (sample_stb) begin t_smp  = cyc; n_smp++;  end
            if (result_wr)  begin t_done = cyc; n_done++; end
        end
    end

    int checks = 0, errs = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_start(output int c0);
        c0 = cyc;
        start_set = 1'b1;
        tick(1);
        start_set = 1'b0;
    endtask

    task automatic wait_mux(string req);
        int m0 = n_mux;
        for (int i = 0; i < 400 && n_mux == m0; i++) tick(1);
        chk(n_mux != m0, req, n_mux, m0 + 1);
    endtask

    task automatic wait_done(string req);
        int d0 = n_done;
        for (int i = 0; i < 400 && n_done == d0; i++) tick(1);
        chk(n_done != d0, req, n_done, d0 + 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, errs);
        $finish;
    end

    initial begin
        int c0, tm, prev, d0, m0;
        rst_n = 1'b0; en = 1'b0; start_set = 1'b0; trig = 1'b0;
        flag_clr = 1'b0; mode = 2'b00; word = '0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk(!start_rd && !flag && !mux_upd && !sample_stb && !result_wr, "R1 reset",
            {start_rd, flag, mux_upd, sample_stb, result_wr}, 0);

        // R12: requests while disabled
        pulse_start(c0);
        tick(10);
        chk(start_rd == 1'b0, "R12 start bit", start_rd, 0);
        chk(n_mux == 0, "R12 no conversion", n_mux, 0);

        // first conversion, single mode
        en = 1'b1;
        tick(3);
        word = 10'h2A5;
        pulse_start(c0);
        wait_mux("R1 start");
        chk((t_mux - c0) >= 2 && (t_mux - c0) <= DIV + 1, "R1 latency", t_mux - c0, DIV);
        tick(5);
        chk(start_rd == 1'b1, "R1 start bit", start_rd, 1);
        wait_done("R3 done");
        chk(t_done - t_mux == FL * DIV, "R3 first length", t_done - t_mux, FL * DIV);
        chk(t_smp - t_mux == FS * DIV + DIV / 2, "R4 first sample", t_smp - t_mux, FS * DIV + DIV / 2);
        chk(int'(result) == 'h2A5, "R5 result", int'(result), 'h2A5);
        chk(flag == 1'b1, "R5 flag", flag, 1);
        chk(start_rd == 1'b0, "R6 start clear", start_rd, 0);
        d0 = n_done;
        tick(3 * NL * DIV);
        chk(n_done == d0, "R6 no restart", n_done, d0);

        // normal conversions at several prescaler phases
        for (int k = 0; k < DIV; k++) begin
            tick(k + 1);
            word = RW'(10'h055 + k * 37);
            pulse_start(c0);
            wait_mux("R2 start");
            chk(flag == 1'b1, "R10 flag kept on start", flag, 1);
            wait_done("R2 done");
            chk(t_done - t_mux == NL * DIV, "R2 length", t_done - t_mux, NL * DIV);
            chk(t_smp - t_mux == NS * DIV + DIV / 2, "R4 sample", t_smp - t_mux, NS * DIV + DIV / 2);
            chk(int'(result) == 'h055 + k * 37, "R5 result", int'(result), 'h055 + k * 37);
        end

        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        chk(flag == 1'b0, "R10 clear", flag, 0);

        // clear coinciding with completion
        pulse_start(c0);
        wait_mux("R10 start");
        tm = t_mux;
        d0 = n_done;
        while (cyc < tm + NL * DIV - 1) tick(1);
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        chk(n_done == d0 + 1, "R10 aligned done", n_done, d0 + 1);
        chk(flag == 1'b1, "R10 set wins", flag, 1);

        // free-running
        mode = 2'b01;
        tick(2);
        pulse_start(c0);
        wait_mux("R7 start");
        prev = t_mux;
        for (int i = 0; i < 4; i++) begin
            wait_done("R7 done");
            chk(t_done - prev == NL * DIV, "R7 spacing", t_done - prev, NL * DIV);
            chk(t_mux == t_done, "R7 chained start", t_mux, t_done);
            chk(start_rd == 1'b1, "R7 start held", start_rd, 1);
            prev = t_done;
        end
        mode = 2'b00;
        wait_done("R6 leave free");
        chk(start_rd == 1'b0, "R6 start clear after free", start_rd, 0);
        chk(t_done - prev == NL * DIV, "R2 last length", t_done - prev, NL * DIV);

        // trigger mode at every prescaler phase
        mode = 2'b10;
        for (int k = 0; k < DIV; k++) begin
            tick(3 + k);
            c0 = cyc;
            d0 = n_done;
            trig = 1'b1;
            wait_mux("R8 start");
            chk(t_mux == c0 + 3, "R8 trigger delay", t_mux - c0, 3);
            tick(12);
            trig = 1'b0;
            tick(2);
            trig = 1'b1;
            tick(4);
            trig = 1'b0;
            wait_done("R8 done");
            chk(t_smp - t_mux == TS * DIV, "R8 sample", t_smp - t_mux, TS * DIV);
            chk(t_done - t_mux == NL * DIV, "R2 trigger length", t_done - t_mux, NL * DIV);
            m0 = n_mux;
            tick(10);
            chk(n_done == d0 + 1 && n_mux == m0, "R9 busy trigger ignored", n_done, d0 + 1);
        end

        // trigger in single mode
        mode = 2'b00;
        m0 = n_mux;
        trig = 1'b1;
        tick(4);
        trig = 1'b0;
        tick(3 * DIV + 4);
        chk(n_mux == m0, "R9 single ignores trigger", n_mux, m0);

        // abort and re-arm
        pulse_start(c0);
        wait_mux("R11 start");
        d0 = n_done;
        tick(30);
        en = 1'b0;
        tick(2);
        chk(start_rd == 1'b0, "R11 start cleared", start_rd, 0);
        tick(120);
        chk(n_done == d0, "R11 no completion", n_done, d0);
        en = 1'b1;
        tick(2);
        pulse_start(c0);
        wait_mux("R11 restart");
        wait_done("R11 done");
        chk(t_done - t_mux == FL * DIV, "R11 first length", t_done - t_mux, FL * DIV);
        chk(t_smp - t_mux == FS * DIV + DIV / 2, "R11 first sample", t_smp - t_mux, FS * DIV + DIV / 2);

        // first conversion started by a trigger
        en = 1'b0;
        tick(3);
        en = 1'b1;
        mode = 2'b10;
        tick(3);
        c0 = cyc;
        trig = 1'b1;
        wait_mux("R8 first start");
        chk(t_mux == c0 + 3, "R8 first delay", t_mux - c0, 3);
        tick(4);
        trig = 1'b0;
        wait_done("R3 trigger first");
        chk(t_smp - t_mux == FS * DIV + DIV / 2, "R8 first sample", t_smp - t_mux, FS * DIV + DIV / 2);
        chk(t_done - t_mux == FL * DIV, "R3 trigger first length", t_done - t_mux, FL * DIV);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

endmodule